// File: doc/BRIEF.md
# Host Port Request/Acknowledge Handshake

This block sits on the external-device side of a host port. An outside agent asks for service through one active-low request output and answers through one active-low acknowledge input. The acknowledge input means different things in different modes. In vector mode it is an interrupt acknowledge: while it is low, the stored vector appears on the data bus. In the two transfer modes it is a DMA strobe. In transfer-read mode it places the receive word on the bus. In transfer-write mode it stores the word on the data inputs into the transmit register when the strobe is released.

The core side fills the receive register, drains the transmit register, loads the vector and raises interrupt events. The request output is always driven to a 0 or a 1. It goes low when the current mode has work pending: an interrupt event in vector mode, an unread receive word in transfer-read mode, or an empty transmit register in transfer-write mode. A small mode register chooses the mode.

Top module: `hostport_hs`

## Requirements
- R1: A synchronous reset selects vector mode and clears the receive, transmit and interrupt pending flags. After reset, `req_n_o` is 1 and `d_oe_o` is 0.
- R2: A one-cycle `mode_set_i` loads `mode_val_i` at the next clock edge, coded 0 = vector, 1 = transfer-read, 2 = transfer-write. Code 3 is ignored and the previous mode is kept.
- R3: In vector mode, while `ack_n_i` is 0, `d_oe_o` is 1 and `d_o` carries the vector with its upper bits zero-filled.
- R4: In vector mode, a one-cycle `core_irq_i` makes `req_n_o` 0 after the next edge. The first edge that sees `ack_n_i` back at 1 after being 0 clears the request.
- R5: In transfer-read mode, while `ack_n_i` is 0, `d_oe_o` is 1 and `d_o` carries the receive word.
- R6: In transfer-read mode, `req_n_o` is 0 from the edge after `core_rx_wr_i` until the edge that sees the acknowledge released.
- R7: In transfer-write mode, `d_oe_o` stays 0. The value on `d_i` in the last clock cycle with `ack_n_i` at 0 is stored at release. A change of `d_i` in the release cycle is not taken. The stored word then shows on `tx_data_o` and `tx_pend_o` becomes 1.
- R8: In transfer-write mode, `req_n_o` is 0 while the transmit register is empty. It goes to 1 once a word is stored, and goes back to 0 after `core_tx_rd_i` consumes the word.
- R9: `d_oe_o` is 0 whenever `ack_n_i` is 1.
- R10: `req_n_o` is never X or Z, in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_set_i | input | 1 | Load the mode register |
| mode_val_i | input | 2 | Mode code to load |
| vec_wr_i | input | 1 | Load the vector register |
| vec_data_i | input | VW | Vector value |
| core_irq_i | input | 1 | Interrupt event from the core |
| core_rx_wr_i | input | 1 | Core deposits a receive word |
| core_rx_data_i | input | DW | Receive word from the core |
| core_tx_rd_i | input | 1 | Core consumes the transmit word |
| tx_data_o | output | DW | Transmit register contents |
| tx_pend_o | output | 1 | Transmit register holds a word |
| rx_pend_o | output | 1 | Receive register holds an unread word |
| ack_n_i | input | 1 | Active-low acknowledge / DMA strobe |
| d_i | input | DW | External data bus in |
| d_o | output | DW | External data bus out |
| d_oe_o | output | 1 | Data bus output enable |
| req_n_o | output | 1 | Active-low service request |

## Verification
The bench uses the defaults DW=32 and VW=8. Because the vector is narrower than the bus, a missing zero-fill shows up in the upper 24 bits during a vector acknowledge. The 32-bit width also lets full-width patterns on the receive and transmit paths reveal swapped or truncated lanes. In the write test, `d_i` changes in the same cycle the strobe is released, which separates a capture at release from a capture one cycle late.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        M_VEC = 2'd0,
        M_DRD = 2'd1,
        M_DWR = 2'd2
    } mode_e;

    typedef struct packed {
        logic low;
        logic rise;
    } ack_ev_t;

    function automatic logic mode_legal(input logic [1:0] code);
        return code != 2'd3;
    endfunction

    function automatic logic drives_bus(input mode_e m);
        return m != M_DWR;
    endfunction

endpackage

// File: rtl/hs_ack.sv
module hs_ack
    import hs_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ack_n_i,
    input  logic [DW-1:0] d_i,
    output ack_ev_t       ev_o,
    output logic [DW-1:0] hold_o
);
    logic ack_n_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_n_prev <= 1'b1;
            hold_o     <= '0;
        end else begin
            ack_n_prev <= ack_n_i;
            if (!ack_n_i)
                hold_o <= d_i;
        end
    end

    always_comb begin
        ev_o.low  = !ack_n_i;
        ev_o.rise = ack_n_i && !ack_n_prev;
    end
endmodule

// File: rtl/hs_state.sv
module hs_state
    import hs_pkg::*;
#(
    parameter int DW = 32,
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_set_i,
    input  logic [1:0]    mode_val_i,
    input  logic          vec_wr_i,
    input  logic [VW-1:0] vec_data_i,
    input  logic          core_irq_i,
    input  logic          core_rx_wr_i,
    input  logic [DW-1:0] core_rx_data_i,
    input  logic          core_tx_rd_i,
    input  ack_ev_t       ev_i,
    input  logic [DW-1:0] hold_i,
    output mode_e         mode_o,
    output logic [VW-1:0] vec_o,
    output logic [DW-1:0] rx_o,
    output logic [DW-1:0] tx_o,
    output logic          irq_pend_o,
    output logic          rx_pend_o,
    output logic          tx_pend_o
);
    logic rel_vec, rel_rd, rel_wr;

    assign rel_vec = ev_i.rise && (mode_o == M_VEC);
    assign rel_rd  = ev_i.rise && (mode_o == M_DRD);
    assign rel_wr  = ev_i.rise && (mode_o == M_DWR);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o     <= M_VEC;
            vec_o      <= '0;
            rx_o       <= '0;
            tx_o       <= '0;
            irq_pend_o <= 1'b0;
            rx_pend_o  <= 1'b0;
            tx_pend_o  <= 1'b0;
        end else begin
            if (mode_set_i && mode_legal(mode_val_i))
                mode_o <= mode_e'(mode_val_i);
            if (vec_wr_i)
                vec_o <= vec_data_i;

            if (core_irq_i)
                irq_pend_o <= 1'b1;
            else if (rel_vec)
                irq_pend_o <= 1'b0;

            if (core_rx_wr_i) begin
                rx_o      <= core_rx_data_i;
                rx_pend_o <= 1'b1;
            end else if (rel_rd) begin
                rx_pend_o <= 1'b0;
            end

            if (rel_wr) begin
                tx_o      <= hold_i;
                tx_pend_o <= 1'b1;
            end else if (core_tx_rd_i) begin
                tx_pend_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hs_drive.sv
module hs_drive
    import hs_pkg::*;
#(
    parameter int DW = 32,
    parameter int VW = 8
) (
    input  mode_e         mode_i,
    input  ack_ev_t       ev_i,
    input  logic [VW-1:0] vec_i,
    input  logic [DW-1:0] rx_i,
    input  logic          irq_pend_i,
    input  logic          rx_pend_i,
    input  logic          tx_pend_i,
    output logic [DW-1:0] d_o,
    output logic          d_oe_o,
    output logic          req_n_o
);
    localparam int PAD = DW - VW;

    logic [DW-1:0] vec_wide;

    generate
        if (PAD > 0) begin : g_pad
            assign vec_wide = {{PAD{1'b0}}, vec_i};
        end else begin : g_nopad
            assign vec_wide = vec_i[DW-1:0];
        end
    endgenerate

    always_comb begin
        d_oe_o = ev_i.low && drives_bus(mode_i);
        d_o    = (mode_i == M_DRD) ? rx_i : vec_wide;
        unique case (mode_i)
            M_VEC:   req_n_o = !irq_pend_i;
            M_DRD:   req_n_o = !rx_pend_i;
            M_DWR:   req_n_o = tx_pend_i;
            default: req_n_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/hostport_hs.sv
module hostport_hs
    import hs_pkg::*;
#(
    parameter int DW = 32,
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_set_i,
    input  logic [1:0]    mode_val_i,
    input  logic          vec_wr_i,
    input  logic [VW-1:0] vec_data_i,
    input  logic          core_irq_i,
    input  logic          core_rx_wr_i,
    input  logic [DW-1:0] core_rx_data_i,
    input  logic          core_tx_rd_i,
    output logic [DW-1:0] tx_data_o,
    output logic          tx_pend_o,
    output logic          rx_pend_o,
    input  logic          ack_n_i,
    input  logic [DW-1:0] d_i,
    output logic [DW-1:0] d_o,
    output logic          d_oe_o,
    output logic          req_n_o
);
    ack_ev_t       ev;
    logic [DW-1:0] hold;
    mode_e         mode_q;
    logic [VW-1:0] vec_q;
    logic [DW-1:0] rx_q;
    logic          irq_pend;

    hs_ack #(.DW(DW)) u_ack (
        .clk     (clk),
        .rst     (rst),
        .ack_n_i (ack_n_i),
        .d_i     (d_i),
        .ev_o    (ev),
        .hold_o  (hold)
    );

    hs_state #(.DW(DW), .VW(VW)) u_state (
        .clk            (clk),
        .rst            (rst),
        .mode_set_i     (mode_set_i),
        .mode_val_i     (mode_val_i),
        .vec_wr_i       (vec_wr_i),
        .vec_data_i     (vec_data_i),
        .core_irq_i     (core_irq_i),
        .core_rx_wr_i   (core_rx_wr_i),
        .core_rx_data_i (core_rx_data_i),
        .core_tx_rd_i   (core_tx_rd_i),
        .ev_i           (ev),
        .hold_i         (hold),
        .mode_o         (mode_q),
        .vec_o          (vec_q),
        .rx_o           (rx_q),
        .tx_o           (tx_data_o),
        .irq_pend_o     (irq_pend),
        .rx_pend_o      (rx_pend_o),
        .tx_pend_o      (tx_pend_o)
    );

    hs_drive #(.DW(DW), .VW(VW)) u_drive (
        .mode_i     (mode_q),
        .ev_i       (ev),
        .vec_i      (vec_q),
        .rx_i       (rx_q),
        .irq_pend_i (irq_pend),
        .rx_pend_i  (rx_pend_o),
        .tx_pend_i  (tx_pend_o),
        .d_o        (d_o),
        .d_oe_o     (d_oe_o),
        .req_n_o    (req_n_o)
    );
endmodule

// File: rtl/hs_chk.sv
module hs_chk
    import hs_pkg::*;
#(
    parameter int DW = 32,
    parameter int VW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          mode_set_i,
    input logic          core_rx_wr_i,
    input logic          ack_n_i,
    input logic [DW-1:0] d_i,
    input logic [DW-1:0] d_o,
    input logic          d_oe_o,
    input logic          req_n_o,
    input logic [DW-1:0] tx_data_o,
    input mode_e         mode,
    input logic [VW-1:0] vec
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (req_n_o && !d_oe_o));

    // R9
    oe_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
        d_oe_o |-> !ack_n_i);

    // R7
    no_drive_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == M_DWR) |-> !d_oe_o);

    // R3
    vector_out_chk: assert property (@(posedge clk) disable iff (rst)
        (d_oe_o && mode == M_VEC) |-> (d_o == DW'(vec)));

    // R7
    write_latch_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ack_n_i) && !$past(rst) && mode == M_DWR) |=> (tx_data_o == $past(d_i, 2)));

    // R6
    read_req_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ack_n_i) && !$past(rst) && mode == M_DRD && !core_rx_wr_i && !mode_set_i)
        |=> req_n_o);

    // R10
    req_known_chk: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(req_n_o));
endmodule

bind hostport_hs hs_chk #(.DW(DW), .VW(VW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_set_i   (mode_set_i),
    .core_rx_wr_i (core_rx_wr_i),
    .ack_n_i      (ack_n_i),
    .d_i          (d_i),
    .d_o          (d_o),
    .d_oe_o       (d_oe_o),
    .req_n_o      (req_n_o),
    .tx_data_o    (tx_data_o),
    .mode         (mode_q),
    .vec          (vec_q)
);

// File: tb/sim_hostport_hs.sv
module sim_hostport_hs;
    localparam int CLK_P = 10;
    localparam int DW = 32;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_set_i = 1'b0;
    logic [1:0]    mode_val_i = '0;
    logic          vec_wr_i = 1'b0;
    logic [VW-1:0] vec_data_i = '0;
    logic          core_irq_i = 1'b0;
    logic          core_rx_wr_i = 1'b0;
    logic [DW-1:0] core_rx_data_i = '0;
    logic          core_tx_rd_i = 1'b0;
    logic [DW-1:0] tx_data_o;
    logic          tx_pend_o;
    logic          rx_pend_o;
    logic          ack_n_i = 1'b1;
    logic [DW-1:0] d_i = '0;
    logic [DW-1:0] d_o;
    logic          d_oe_o;
    logic          req_n_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    hostport_hs #(.DW(DW), .VW(VW)) u0 (
        .clk(clk), .rst(rst), .mode_set_i(mode_set_i), .mode_val_i(mode_val_i),
        .vec_wr_i(vec_wr_i), .vec_data_i(vec_data_i), .core_irq_i(core_irq_i),
        .core_rx_wr_i(core_rx_wr_i), .core_rx_data_i(core_rx_data_i),
        .core_tx_rd_i(core_tx_rd_i), .tx_data_o(tx_data_o), .tx_pend_o(tx_pend_o),
        .rx_pend_o(rx_pend_o), .ack_n_i(ack_n_i), .d_i(d_i), .d_o(d_o),
        .d_oe_o(d_oe_o), .req_n_o(req_n_o)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] code);
        mode_set_i = 1'b1;
        mode_val_i = code;
        step();
        mode_set_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        check("R1 req_n", 32'(req_n_o), 32'd1);
        check("R1 oe", 32'(d_oe_o), 32'd0);
        check("R1 pend", {30'd0, tx_pend_o, rx_pend_o}, 32'd0);
        check("R10 req known", 32'($isunknown(req_n_o)), 32'd0);
        ack_n_i = 1'b0;
        step();
        check("R1 vector mode oe", 32'(d_oe_o), 32'd1);
        ack_n_i = 1'b1;
        step();
    endtask

    task automatic t_vector();
        vec_wr_i = 1'b1;
        vec_data_i = 8'hA5;
        step();
        vec_wr_i = 1'b0;
        ack_n_i = 1'b0;
        step();
        check("R3 oe", 32'(d_oe_o), 32'd1);
        check("R3 vector", d_o, 32'h0000_00A5);
        ack_n_i = 1'b1;
        step();
        check("R9 oe released", 32'(d_oe_o), 32'd0);
    endtask

    task automatic t_irq();
        core_irq_i = 1'b1;
        step();
        core_irq_i = 1'b0;
        check("R4 req asserted", 32'(req_n_o), 32'd0);
        step();
        check("R4 req held", 32'(req_n_o), 32'd0);
        ack_n_i = 1'b0;
        step();
        ack_n_i = 1'b1;
        step();
        check("R4 req cleared", 32'(req_n_o), 32'd1);
    endtask

    task automatic rd_word(input logic [DW-1:0] w);
        core_rx_wr_i = 1'b1;
        core_rx_data_i = w;
        step();
        core_rx_wr_i = 1'b0;
        check("R6 req on data", 32'(req_n_o), 32'd0);
        ack_n_i = 1'b0;
        step();
        check("R5 oe", 32'(d_oe_o), 32'd1);
        check("R5 rx word", d_o, w);
        check("R6 req during ack", 32'(req_n_o), 32'd0);
        ack_n_i = 1'b1;
        step();
        check("R6 req cleared", 32'(req_n_o), 32'd1);
        check("R6 rx_pend", 32'(rx_pend_o), 32'd0);
    endtask

    task automatic t_dma_read();
        set_mode(2'd1);
        check("R2 read mode idle req", 32'(req_n_o), 32'd1);
        rd_word(32'hDEAD_BEEF);
        rd_word(32'h1234_5678);
    endtask

    task automatic t_dma_write();
        set_mode(2'd2);
        check("R8 empty req", 32'(req_n_o), 32'd0);
        ack_n_i = 1'b0;
        d_i = 32'h1111_1111;
        step();
        check("R7 no oe", 32'(d_oe_o), 32'd0);
        d_i = 32'hCAFE_F00D;
        step();
        ack_n_i = 1'b1;
        d_i = 32'h0000_0000;
        step();
        check("R7 tx word", tx_data_o, 32'hCAFE_F00D);
        check("R7 tx_pend", 32'(tx_pend_o), 32'd1);
        check("R8 req off when full", 32'(req_n_o), 32'd1);
        core_tx_rd_i = 1'b1;
        step();
        core_tx_rd_i = 1'b0;
        check("R8 req after consume", 32'(req_n_o), 32'd0);
        check("R8 tx_pend cleared", 32'(tx_pend_o), 32'd0);
    endtask

    task automatic t_mode_code();
        set_mode(2'd3);
        check("R2 code3 keeps write req", 32'(req_n_o), 32'd0);
        ack_n_i = 1'b0;
        step();
        check("R2 code3 keeps write mode", 32'(d_oe_o), 32'd0);
        ack_n_i = 1'b1;
        step();
        core_tx_rd_i = 1'b1;
        step();
        core_tx_rd_i = 1'b0;
        set_mode(2'd0);
        ack_n_i = 1'b0;
        step();
        check("R2 back to vector", d_o, 32'h0000_00A5);
        check("R2 vector oe", 32'(d_oe_o), 32'd1);
        ack_n_i = 1'b1;
        step();
        check("R10 req known", 32'($isunknown(req_n_o)), 32'd0);
    endtask

    initial begin
        t_reset();
        t_vector();
        t_irq();
        t_dma_read();
        t_dma_write();
        t_mode_code();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule